// File: doc/BRIEF.md
# Indexed Block-Access I2C Register Target

This block is an I2C target that gives a host access to a small bank of 8-bit configuration registers. It oversamples SCL and SDA on the system clock, and it drives SDA only by pulling it low through an output-enable. A write frame carries a starting register index and then a byte count, followed by the data for consecutive registers. A read frame first sets the index with a short write, then uses a repeated start to switch direction. The target answers with a byte count and then streams consecutive registers for as long as the host acknowledges.

The bank keeps its power-on defaults until the host changes them. Some bits are read-only views of strap inputs that are latched outside the block. Every committed data byte also appears on a one-cycle write strobe with its index and value, so that neighbouring logic can follow the updates. The current bank contents are always visible on a flat output bus.

Top module: `idx_block_i2c_target`

## Requirements
- R1: The target acknowledges an address byte of 0xD2 (write) or 0xD3 (read), that is a 7-bit address of 0x69 with R/W in the LSB. It answers any other address byte with a NACK and then leaves SDA released, acknowledging nothing, until the next start.
- R2: In a write frame the byte after the address is the starting index N and the next byte is the count X; both are acknowledged. Data bytes go to N, N+1, and so on, and each one is acknowledged. Each committed byte gives one wrStb pulse, carrying its index on wrIdx and its value on wrData.
- R3: A data byte that would exceed the count X is answered with a NACK. It is not committed, and the target then stays released until the next start. With X = 0, the first data byte is already refused.
- R4: After a repeated start with 0xD3, the target sends the stored count first. The stored count is the count byte of the most recent write frame, or 5 after reset. The target then sends registers N, N+1, and so on, for as long as the host acknowledges. A host NACK ends the read and releases SDA.
- R5: Reset defaults: register 0 = 0x00, register 1 bits 2:0 = 3'b111, register 2 = 0xFF, register 3 = 0x37. cfgBank holds register i at bits 8i+7:8i.
- R6: Register 1 bits 7:3 always show fsStrap[4:0], and register 4 bit 7 always shows multiSel. Register 4 bits 6:0 read as 0. Writes do not change these bits; writes change only register 0, register 1 bits 2:0, register 2 and register 3.
- R7: An index of 5 or above reads as 0x00 and ignores written data, although a write to it still pulses wrStb. The index advances by one per data byte in either direction and wraps from 255 to 0.
- R8: A stop or start that arrives before all eight bits of a byte have been received discards that byte. No strobe is issued and no register changes.
- R9: sdaOe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | I2C clock as seen on the wire |
| sdaIn | input | 1 | I2C data as seen on the wire |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| fsStrap | input | 5 | Latched frequency-select straps, shown in register 1 bits 7:3 |
| multiSel | input | 1 | Current-multiplier strap, shown in register 4 bit 7 |
| wrStb | output | 1 | One-cycle pulse for each committed data byte |
| wrIdx | output | 8 | Register index of the committed byte |
| wrData | output | 8 | Value of the committed byte |
| cfgBank | output | 40 | Current view of registers 0 to 4, register i at bits 8i+7:8i |

## Verification
The hardest cases to reach are a frame cut short inside a byte and a data byte that arrives after the count is used up. A host that works by whole bytes never produces either. The bench therefore drives the bus one bit at a time. It can issue a stop after four bits or a repeated start after three, and it can send one more byte than the count allows. It then reads the bank back over the bus and on cfgBank. A scoreboard of expected write strobes flags any commit of a discarded byte.

// File: rtl/idxi2c_pkg.sv
package idxi2c_pkg;
  localparam int REG_W = 8;
  localparam int BANK_REGS = 5;
  localparam logic [6:0] TARGET_ADDR = 7'h69;

  typedef struct packed {
    logic             ldIdx;
    logic             incIdx;
    logic             ldCnt;
    logic             wrEn;
    logic [REG_W-1:0] byteVal;
  } ctlStrobe_t;

  function automatic logic [REG_W-1:0] rwMask(input int i);
    case (i)
      0, 2, 3: return 8'hFF;
      1:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] resetVal(input int i);
    case (i)
      1:       return 8'h07;
      2:       return 8'hFF;
      3:       return 8'h37;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] roBits(input int i, input logic [4:0] fs,
                                              input logic ms);
    if (i == 1) return {fs, 3'b000};
    else if (i == 4) return {ms, 7'b0000000};
    else return 8'h00;
  endfunction
endpackage

// File: rtl/idxi2c_ctrl.sv
module idxi2c_ctrl
  import idxi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = TARGET_ADDR
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [REG_W-1:0] cntVal,
  input  logic [REG_W-1:0] rdData,
  output ctlStrobe_t       str,
  output logic             sdaOe
);
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_HACK} state_t;
  typedef enum logic [1:0] {PH_ADDR, PH_IDX, PH_CNT, PH_WDATA} phase_t;

  localparam int BIT_W = $clog2(REG_W + 1);
  localparam logic [BIT_W-1:0] FULL_BYTE = BIT_W'(REG_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(REG_W - 1);

  logic [1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclS, sdaS;
  logic sclRise, sclFall, startDet, stopDet;

  state_t state;
  phase_t phase;
  logic [BIT_W-1:0] bitCnt;
  logic [REG_W-1:0] shReg, txShift, remaining;
  logic rdMode, hostAcked, oeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclQ <= sclSync[1];
      sdaQ <= sdaSync[1];
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];
  assign sclRise = sclS & ~sclQ;
  assign sclFall = ~sclS & sclQ;
  assign startDet = sclS & sclQ & sdaQ & ~sdaS;
  assign stopDet = sclS & sclQ & ~sdaQ & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= PH_ADDR;
      bitCnt <= '0;
      shReg <= '0;
      txShift <= '0;
      remaining <= '0;
      rdMode <= 1'b0;
      hostAcked <= 1'b0;
      oeQ <= 1'b0;
      str <= '0;
    end else begin
      str <= '0;
      if (stopDet) begin
        state <= ST_IDLE;
        oeQ <= 1'b0;
      end else if (startDet) begin
        state <= ST_RX;
        phase <= PH_ADDR;
        bitCnt <= '0;
        hostAcked <= 1'b0;
        oeQ <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt != FULL_BYTE) begin
              shReg <= {shReg[REG_W-2:0], sdaS};
              bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == FULL_BYTE) begin
              bitCnt <= '0;
              case (phase)
                PH_ADDR: begin
                  if (shReg[7:1] == DEV_ADDR) begin
                    rdMode <= shReg[0];
                    oeQ <= 1'b1;
                    state <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_IDX: begin
                  str.ldIdx <= 1'b1;
                  str.byteVal <= shReg;
                  oeQ <= 1'b1;
                  state <= ST_ACK;
                end
                PH_CNT: begin
                  str.ldCnt <= 1'b1;
                  str.byteVal <= shReg;
                  remaining <= shReg;
                  oeQ <= 1'b1;
                  state <= ST_ACK;
                end
                default: begin
                  if (remaining != '0) begin
                    str.wrEn <= 1'b1;
                    str.incIdx <= 1'b1;
                    str.byteVal <= shReg;
                    remaining <= remaining - 1'b1;
                    oeQ <= 1'b1;
                    state <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              if (phase == PH_ADDR && rdMode) begin
                txShift <= cntVal;
                oeQ <= ~cntVal[REG_W-1];
                bitCnt <= '0;
                state <= ST_TX;
              end else begin
                oeQ <= 1'b0;
                state <= ST_RX;
                case (phase)
                  PH_ADDR: phase <= PH_IDX;
                  PH_IDX:  phase <= PH_CNT;
                  default: phase <= PH_WDATA;
                endcase
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                oeQ <= 1'b0;
                hostAcked <= 1'b0;
                state <= ST_HACK;
              end else begin
                txShift <= {txShift[REG_W-2:0], 1'b0};
                oeQ <= ~txShift[REG_W-2];
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          ST_HACK: begin
            if (sclRise) begin
              if (sdaS) state <= ST_IDLE;
              else hostAcked <= 1'b1;
            end else if (sclFall && hostAcked) begin
              txShift <= rdData;
              oeQ <= ~rdData[REG_W-1];
              str.incIdx <= 1'b1;
              bitCnt <= '0;
              state <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe = oeQ;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(oeQ) |-> !$past(sclS)); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !oeQ); // R1

  AST_COMMIT_FULL_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    str.wrEn |-> ($past(bitCnt) == FULL_BYTE)); // R8

  AST_WRITE_DIR_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    str.wrEn |-> !rdMode); // R2
endmodule

// File: rtl/idxi2c_regs.sv
module idxi2c_regs
  import idxi2c_pkg::*;
#(
  parameter int NUM_REGS = BANK_REGS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                str,
  input  logic [4:0]                fsStrap,
  input  logic                      multiSel,
  output logic [REG_W-1:0]          cntVal,
  output logic [REG_W-1:0]          rdData,
  output logic                      wrStb,
  output logic [REG_W-1:0]          wrIdx,
  output logic [REG_W-1:0]          wrData,
  output logic [NUM_REGS*REG_W-1:0] cfgBank
);
  localparam logic [REG_W-1:0] CNT_RESET = REG_W'(NUM_REGS);

  logic [REG_W-1:0] idxQ;
  logic [REG_W-1:0] view [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ <= '0;
      cntVal <= CNT_RESET;
      wrStb <= 1'b0;
      wrIdx <= '0;
      wrData <= '0;
    end else begin
      if (str.ldIdx) idxQ <= str.byteVal;
      else if (str.incIdx) idxQ <= idxQ + 1'b1;
      if (str.ldCnt) cntVal <= str.byteVal;
      wrStb <= str.wrEn;
      if (str.wrEn) begin
        wrIdx <= idxQ;
        wrData <= str.byteVal;
      end
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [REG_W-1:0] store;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) store <= resetVal(i) & rwMask(i);
      else if (str.wrEn && idxQ == REG_W'(i)) store <= str.byteVal & rwMask(i);
    end
    assign view[i] = (store & rwMask(i)) | roBits(i, fsStrap, multiSel);
    assign cfgBank[i*REG_W +: REG_W] = view[i];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idxQ == REG_W'(i)) rdData = view[i];
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(str.wrEn) && !$past(str.ldIdx)) |-> (idxQ == $past(idxQ) + 8'd1)); // R7

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb); // R2
endmodule

// File: rtl/idx_block_i2c_target.sv
module idx_block_i2c_target
  import idxi2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = TARGET_ADDR,
  parameter int NUM_REGS = BANK_REGS
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  output logic                      sdaOe,
  input  logic [4:0]                fsStrap,
  input  logic                      multiSel,
  output logic                      wrStb,
  output logic [REG_W-1:0]          wrIdx,
  output logic [REG_W-1:0]          wrData,
  output logic [NUM_REGS*REG_W-1:0] cfgBank
);
  ctlStrobe_t str;
  logic [REG_W-1:0] cntVal, rdData;

  idxi2c_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .cntVal(cntVal), .rdData(rdData), .str(str), .sdaOe(sdaOe)
  );

  idxi2c_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rstN(rstN), .str(str), .fsStrap(fsStrap), .multiSel(multiSel),
    .cntVal(cntVal), .rdData(rdData), .wrStb(wrStb), .wrIdx(wrIdx),
    .wrData(wrData), .cfgBank(cfgBank)
  );
endmodule

// File: tb/idx_block_i2c_target_tb.sv
module idx_block_i2c_target_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclHost = 1'b1;
  logic sdaHost = 1'b1;
  logic [4:0] fsV = 5'b10110;
  logic msV = 1'b1;
  logic sdaOe, wrStb;
  logic [7:0] wrIdx, wrData;
  logic [39:0] cfgBank;
  wire sdaBus = sdaHost & ~sdaOe;

  int checks = 0;
  int errs = 0;
  int oeHighChanges = 0;
  bit done = 1'b0;
  logic [15:0] expQ[$];

  logic [7:0] sh0 = 8'h00, sh2 = 8'hFF, sh3 = 8'h37;
  logic [2:0] sh1 = 3'b111;
  logic [7:0] cntModel = 8'd5;

  always #2.5 clk = ~clk;

  idx_block_i2c_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclHost), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .fsStrap(fsV), .multiSel(msV), .wrStb(wrStb), .wrIdx(wrIdx),
    .wrData(wrData), .cfgBank(cfgBank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [7:0] i);
    case (i)
      8'd0: return sh0;
      8'd1: return {fsV, sh1};
      8'd2: return sh2;
      8'd3: return sh3;
      8'd4: return {msV, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic applyWrite(input logic [7:0] i, input logic [7:0] d);
    case (i)
      8'd0: sh0 = d;
      8'd1: sh1 = d[2:0];
      8'd2: sh2 = d;
      8'd3: sh3 = d;
      default: ;
    endcase
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaHost = 1'b1; waitQ();
    sclHost = 1'b1; waitQ();
    sdaHost = 1'b0; waitQ();
    sclHost = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaHost = 1'b0; waitQ();
    sclHost = 1'b1; waitQ();
    sdaHost = 1'b1; waitQ();
    waitQ();
  endtask

  task automatic sendBit(input logic b);
    sdaHost = b; waitQ();
    sclHost = 1'b1; waitQ(); waitQ();
    sclHost = 1'b0; waitQ();
  endtask

  task automatic recvBit(output logic b);
    sdaHost = 1'b1; waitQ();
    sclHost = 1'b1; waitQ();
    b = sdaBus; waitQ();
    sclHost = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    recvBit(b);
    ack = ~b;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic hostAck);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recvBit(b);
      v[i] = b;
    end
    sendBit(~hostAck);
  endtask

  task automatic writeFrame(input logic [7:0] n, input logic [7:0] x, input int nSend,
                            input logic [7:0] d [6]);
    logic a;
    i2cStart();
    sendByte(8'hD2, a); chk("R1 write address ack", a, 1'b1);
    sendByte(n, a);     chk("R2 index ack", a, 1'b1);
    sendByte(x, a);     chk("R2 count ack", a, 1'b1);
    cntModel = x;
    for (int i = 0; i < nSend; i++) begin
      if (i < x) begin
        expQ.push_back({n + 8'(i), d[i]});
        applyWrite(n + 8'(i), d[i]);
        sendByte(d[i], a);
        chk("R2 data ack", a, 1'b1);
      end else begin
        sendByte(d[i], a);
        chk("R3 byte past count nacked", a, 1'b0);
        break;
      end
    end
    i2cStop();
  endtask

  task automatic readFrame(input logic [7:0] n, input int nRead, input string req);
    logic a;
    logic [7:0] v;
    i2cStart();
    sendByte(8'hD2, a); chk("R1 write address ack", a, 1'b1);
    sendByte(n, a);     chk("R4 index ack", a, 1'b1);
    i2cStart();
    sendByte(8'hD3, a); chk("R1 read address ack", a, 1'b1);
    recvByte(v, 1'b1);  chk("R4 count byte", v, cntModel);
    for (int i = 0; i < nRead; i++) begin
      recvByte(v, i != nRead - 1);
      chk(req, v, expRead(n + 8'(i)));
    end
    chk("R4 released after host nack", sdaOe, 1'b0);
    i2cStop();
  endtask

  task automatic checkBank(input string req);
    for (int i = 0; i < 5; i++) chk(req, cfgBank[i*8 +: 8], expRead(8'(i)));
  endtask

  always @(negedge clk) begin
    if (rstN && wrStb) begin
      checks++;
      if (expQ.size() == 0) begin
        errs++;
        $display("FAIL R8 unexpected strobe actual=%0h expected=none", {wrIdx, wrData});
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        if ({wrIdx, wrData} !== e) begin
          errs++;
          $display("FAIL R2 strobe actual=%0h expected=%0h", {wrIdx, wrData}, e);
        end
      end
    end
  end

  logic prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN && sdaOe != prevOe && sclHost) oeHighChanges++;
    prevOe = sdaOe;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    chk("R5 sdaOe released in reset", sdaOe, 1'b0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkBank("R5 reset default");

    readFrame(8'd0, 5, "R5 default readback");

    writeFrame(8'd0, 8'd3, 3, '{8'hA5, 8'h3C, 8'h0F, 8'h00, 8'h00, 8'h00});
    checkBank("R2 bank after write");
    readFrame(8'd0, 4, "R2 readback after write");

    i2cStart();
    sendByte(8'hA4, a); chk("R1 foreign address nacked", a, 1'b0);
    sendByte(8'h00, a); chk("R1 released until next start", a, 1'b0);
    i2cStop();
    checkBank("R1 bank untouched by foreign frame");

    writeFrame(8'd3, 8'd1, 2, '{8'h5E, 8'h77, 8'h00, 8'h00, 8'h00, 8'h00});
    checkBank("R3 only counted bytes committed");
    writeFrame(8'd0, 8'd0, 1, '{8'h99, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    checkBank("R3 zero count commits nothing");

    writeFrame(8'd0, 8'd5, 5, '{8'hFF, 8'hFF, 8'h12, 8'h34, 8'hFF, 8'h00});
    chk("R6 reg1 read-only bits", cfgBank[15:8], {fsV, 3'b111});
    chk("R6 reg4 read-only bits", cfgBank[39:32], {msV, 7'b0});
    fsV = 5'b01001;
    msV = 1'b0;
    repeat (2) @(negedge clk);
    checkBank("R6 straps reflected");
    readFrame(8'd1, 4, "R6 readback with straps");

    writeFrame(8'd7, 8'd1, 1, '{8'hAA, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00});
    checkBank("R7 write to unimplemented index ignored");
    readFrame(8'd6, 2, "R7 unimplemented index reads zero");
    readFrame(8'hFF, 3, "R7 index wraps");

    i2cStart();
    sendByte(8'hD2, a); chk("R1 write address ack", a, 1'b1);
    sendByte(8'd3, a);  chk("R8 index ack", a, 1'b1);
    sendByte(8'd2, a);  chk("R8 count ack", a, 1'b1);
    cntModel = 8'd2;
    expQ.push_back({8'd3, 8'h11});
    applyWrite(8'd3, 8'h11);
    sendByte(8'h11, a); chk("R8 first byte ack", a, 1'b1);
    for (int i = 0; i < 4; i++) sendBit(i[0]);
    i2cStop();
    checkBank("R8 stop mid-byte discards");

    i2cStart();
    sendByte(8'hD2, a); chk("R1 write address ack", a, 1'b1);
    sendByte(8'd0, a);  chk("R8 index ack", a, 1'b1);
    sendByte(8'd1, a);  chk("R8 count ack", a, 1'b1);
    cntModel = 8'd1;
    for (int i = 0; i < 3; i++) sendBit(1'b0);
    i2cStart();
    i2cStop();
    checkBank("R8 start mid-byte discards");

    chk("R9 sdaOe never changed with SCL high", oeHighChanges, 0);
    chk("R2 all expected strobes seen", expQ.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule